// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Element Row

This block is one row of identical 1-bit processing elements that all execute the same broadcast instruction each clock. Every element owns a 64-entry by 1-bit left memory, an 8-entry by 1-bit right memory, a carry register and a write-enable flag. In one cycle an element reads one bit from each memory, combines them in a 1-bit ALU, and writes the result back into one of the memories. Multi-bit arithmetic is done bit-serially: operands sit at successive addresses, and the carry register links one cycle to the next.

The first ALU operand is the element's own left-memory read bit or a tap from another element. Taps reach 1, 2 or 4 places in either direction along the row, or come from the row above or the row below through plain ports. A run-time chaining mode fuses 2 or 4 adjacent elements into one wider unit. Inside a unit the carry ripples from element to element within the cycle, so the unit processes 2 or 4 bits per cycle. A per-element flag lets an instruction write back only where the flag is set.

Elements are numbered 0 to NPE-1. For a tap at distance d, "left" means element i+d and "right" means element i-d. Within a fused unit the lowest-numbered element holds the least significant bit.

Top module: `simd_pe_row`

## Requirements
- R1: After reset, every left and right memory bit, every carry register and the chaining mode are 0, and every write-enable flag is 1.
- R2: Opcodes AND (3), OR (4), XOR (5) and PASS (6) compute a&b, a|b, a^b and a. The result is written to the memory chosen by `wdst_i` (0 = left, 1 = right) at `waddr_i`, and it is readable from the next cycle. Opcode values are NOP=0, ADD=1, SUB=2, CLRC=7, SETC=8, LDV=9 and CFGC=10.
- R3: `src_i` selects the first operand. The codes are SELF=0, LEFT1=1, LEFT2=2, LEFT4=3, RIGHT1=4, RIGHT2=5, RIGHT4=6, ABOVE=7 (bit i of `above_i`) and BELOW=8 (bit i of `below_i`). A left tap at distance d reads element i+d and a right tap reads element i-d.
- R4: A tap that would reach past either end of the row yields 0.
- R5: ADD computes sum = a^b^cin and stores the carry-out in the carry register. CLRC clears the carry. An n-bit bit-serial add therefore takes n+1 instructions, and the final carry is visible on `carry_o`.
- R6: SUB adds the inverted second operand. After SETC presets the carry to 1, n SUB cycles yield a minus b modulo 2^n.
- R7: With chaining mode 2'b10 (loaded by CFGC from `cfg_i`), each pair {2j, 2j+1} is one unit. The carry from element 2j feeds element 2j+1 in the same cycle, and element 2j takes its carry from element 2j+1's register. The mode holds until the next CFGC.
- R8: With chaining mode 2'b11, each group of 4 adjacent elements (starting at a multiple of 4) is one unit with a 4-element ripple. Modes 2'b00 and 2'b01 keep every element independent.
- R9: LDV loads each element's write-enable flag from its selected first operand. A writing opcode leaves the memory of an element with a clear flag unchanged.
- R10: A write touches only the selected memory. The right memory uses the low 3 bits of `waddr_i`. A cycle that reads and writes the same memory must use differing addresses.
- R11: NOP changes no memory, carry, flag or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Broadcast opcode |
| src_i | input | 4 | First-operand source select |
| laddr_i | input | 6 | Left memory read address |
| raddr_i | input | 3 | Right memory read address |
| wdst_i | input | 1 | Write destination: 0 left, 1 right |
| waddr_i | input | 6 | Write address |
| cfg_i | input | 2 | Chaining mode value for CFGC |
| above_i | input | NPE | Per-element bits from the row above |
| below_i | input | NPE | Per-element bits from the row below |
| d1_o | output | NPE | Left memory read bits (also feed the neighbouring rows) |
| d2_o | output | NPE | Right memory read bits |
| carry_o | output | NPE | Carry registers |

## Verification
The read bits `d1_o` and `d2_o` follow the read addresses combinationally, so each read check is due in the same cycle as the NOP that sets its addresses. A write or carry update from one instruction shows up from the next cycle, because a single register stage lies in between. The driver holds each instruction for exactly one cycle, from a falling edge to the next falling edge, and queues the expected value with it. The monitor compares the queued values 1 ns after that falling edge, well clear of the rising edge. Arithmetic expectations come from integer sums over each fused group, not from a bit-level model of the chain.

// File: rtl/pe_row_pkg.sv
package pe_row_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_PASS = 4'd6,
    OP_CLRC = 4'd7,
    OP_SETC = 4'd8,
    OP_LDV  = 4'd9,
    OP_CFGC = 4'd10
  } pe_op_e;

  typedef enum logic [3:0] {
    SRC_SELF   = 4'd0,
    SRC_LEFT1  = 4'd1,
    SRC_LEFT2  = 4'd2,
    SRC_LEFT4  = 4'd3,
    SRC_RIGHT1 = 4'd4,
    SRC_RIGHT2 = 4'd5,
    SRC_RIGHT4 = 4'd6,
    SRC_ABOVE  = 4'd7,
    SRC_BELOW  = 4'd8
  } pe_src_e;

  function automatic logic fa_sum(logic a, logic b, logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic op_writes(pe_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_XOR) || (op == OP_PASS);
  endfunction

  function automatic int unit_width(logic [1:0] mode);
    case (mode)
      2'b10:   return 2;
      2'b11:   return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/pe_tap_mux.sv
module pe_tap_mux
  import pe_row_pkg::*;
#(
  parameter int NPE = 8
) (
  input  pe_src_e        src_i,
  input  logic [NPE-1:0] d1_i,
  input  logic [NPE-1:0] above_i,
  input  logic [NPE-1:0] below_i,
  output logic [NPE-1:0] opnd_o
);

  function automatic logic tap(logic [NPE-1:0] v, int idx);
    if (idx >= 0 && idx < NPE) return v[idx];
    return 1'b0;
  endfunction

  for (genvar i = 0; i < NPE; i++) begin : g_el
    always_comb begin
      case (src_i)
        SRC_SELF:   opnd_o[i] = d1_i[i];
        SRC_LEFT1:  opnd_o[i] = tap(d1_i, i + 1);
        SRC_LEFT2:  opnd_o[i] = tap(d1_i, i + 2);
        SRC_LEFT4:  opnd_o[i] = tap(d1_i, i + 4);
        SRC_RIGHT1: opnd_o[i] = tap(d1_i, i - 1);
        SRC_RIGHT2: opnd_o[i] = tap(d1_i, i - 2);
        SRC_RIGHT4: opnd_o[i] = tap(d1_i, i - 4);
        SRC_ABOVE:  opnd_o[i] = above_i[i];
        SRC_BELOW:  opnd_o[i] = below_i[i];
        default:    opnd_o[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pe_carry_chain.sv
module pe_carry_chain
  import pe_row_pkg::*;
#(
  parameter int NPE = 8
) (
  input  logic [1:0]     mode_i,
  input  logic [NPE-1:0] a_i,
  input  logic [NPE-1:0] b_i,
  input  logic [NPE-1:0] carry_q_i,
  output logic [NPE-1:0] cin_o
);

  always_comb begin
    logic [NPE-1:0] c;
    int k;
    int prv;
    int msb;
    c = '0;
    k = unit_width(mode_i);
    for (int i = 0; i < NPE; i++) begin
      prv = (i > 0) ? i - 1 : 0;
      msb = (i + k - 1 < NPE) ? i + k - 1 : NPE - 1;
      if ((i & (k - 1)) == 0) c[i] = carry_q_i[msb];
      else                    c[i] = fa_carry(a_i[prv], b_i[prv], c[prv]);
    end
    cin_o = c;
  end

endmodule

// File: rtl/pe_cell.sv
module pe_cell
  import pe_row_pkg::*;
#(
  parameter int LDEPTH = 64,
  parameter int RDEPTH = 8,
  localparam int LAW = $clog2(LDEPTH),
  localparam int RAW = $clog2(RDEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  pe_op_e         op_i,
  input  logic [LAW-1:0] laddr_i,
  input  logic [RAW-1:0] raddr_i,
  input  logic           wdst_i,
  input  logic [LAW-1:0] waddr_i,
  input  logic           opnd_a_i,
  input  logic           opnd_b_i,
  input  logic           cin_i,
  output logic           d1_o,
  output logic           d2_o,
  output logic           carry_o
);

  logic lmem_q [LDEPTH];
  logic rmem_q [RDEPTH];
  logic carry_q, vflag_q;
  logic result, carry_d, wr_fire;

  assign d1_o    = lmem_q[laddr_i];
  assign d2_o    = rmem_q[raddr_i];
  assign carry_o = carry_q;
  assign wr_fire = op_writes(op_i) && vflag_q;

  always_comb begin
    result  = 1'b0;
    carry_d = carry_q;
    case (op_i)
      OP_ADD, OP_SUB: begin
        result  = fa_sum(opnd_a_i, opnd_b_i, cin_i);
        carry_d = fa_carry(opnd_a_i, opnd_b_i, cin_i);
      end
      OP_AND:  result  = opnd_a_i & opnd_b_i;
      OP_OR:   result  = opnd_a_i | opnd_b_i;
      OP_XOR:  result  = opnd_a_i ^ opnd_b_i;
      OP_PASS: result  = opnd_a_i;
      OP_CLRC: carry_d = 1'b0;
      OP_SETC: carry_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LDEPTH; i++) lmem_q[i] <= 1'b0;
      for (int i = 0; i < RDEPTH; i++) rmem_q[i] <= 1'b0;
      carry_q <= 1'b0;
      vflag_q <= 1'b1;
    end else begin
      carry_q <= carry_d;
      if (op_i == OP_LDV) vflag_q <= opnd_a_i;
      if (wr_fire) begin
        if (wdst_i) rmem_q[waddr_i[RAW-1:0]] <= result;
        else        lmem_q[waddr_i]          <= result;
      end
    end
  end

  assert_masked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_writes(op_i) && !vflag_q && !wdst_i) |=>
      lmem_q[$past(waddr_i)] == $past(lmem_q[waddr_i]));

  assert_clrc_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CLRC) |=> (carry_o == 1'b0));

  assert_setc_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SETC) |=> (carry_o == 1'b1));

  assert_nop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NOP) |=> ($stable(carry_q) && $stable(vflag_q)));

endmodule

// File: rtl/simd_pe_row.sv
module simd_pe_row
  import pe_row_pkg::*;
#(
  parameter int NPE    = 8,
  parameter int LDEPTH = 64,
  parameter int RDEPTH = 8,
  localparam int LAW = $clog2(LDEPTH),
  localparam int RAW = $clog2(RDEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     op_i,
  input  logic [3:0]     src_i,
  input  logic [LAW-1:0] laddr_i,
  input  logic [RAW-1:0] raddr_i,
  input  logic           wdst_i,
  input  logic [LAW-1:0] waddr_i,
  input  logic [1:0]     cfg_i,
  input  logic [NPE-1:0] above_i,
  input  logic [NPE-1:0] below_i,
  output logic [NPE-1:0] d1_o,
  output logic [NPE-1:0] d2_o,
  output logic [NPE-1:0] carry_o
);

  pe_op_e         op;
  pe_src_e        src;
  logic [1:0]     mode_q;
  logic [NPE-1:0] d1, d2, opnd_a, opnd_b, cin, carry_q;

  assign op     = pe_op_e'(op_i);
  assign src    = pe_src_e'(src_i);
  assign opnd_b = (op == OP_SUB) ? ~d2 : d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mode_q <= 2'b00;
    else if (op == OP_CFGC)  mode_q <= cfg_i;
  end

  pe_tap_mux #(.NPE(NPE)) u_mux (
    .src_i(src), .d1_i(d1), .above_i(above_i), .below_i(below_i), .opnd_o(opnd_a)
  );

  pe_carry_chain #(.NPE(NPE)) u_chain (
    .mode_i(mode_q), .a_i(opnd_a), .b_i(opnd_b), .carry_q_i(carry_q), .cin_o(cin)
  );

  for (genvar i = 0; i < NPE; i++) begin : g_pe
    pe_cell #(.LDEPTH(LDEPTH), .RDEPTH(RDEPTH)) u_cell (
      .clk(clk), .rst_n(rst_n), .op_i(op),
      .laddr_i(laddr_i), .raddr_i(raddr_i), .wdst_i(wdst_i), .waddr_i(waddr_i),
      .opnd_a_i(opnd_a[i]), .opnd_b_i(opnd_b[i]), .cin_i(cin[i]),
      .d1_o(d1[i]), .d2_o(d2[i]), .carry_o(carry_q[i])
    );
  end

  assign d1_o    = d1;
  assign d2_o    = d2;
  assign carry_o = carry_q;

  assert_left_rw_split_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_writes(op) && !wdst_i) |-> (waddr_i != laddr_i));

  assert_right_rw_split_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_writes(op) && wdst_i) |-> (waddr_i[RAW-1:0] != raddr_i));

  assert_low_edge_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_RIGHT1) |-> (opnd_a[0] == 1'b0));

  assert_high_edge_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_LEFT1) |-> (opnd_a[NPE-1] == 1'b0));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_CFGC) |=> $stable(mode_q));

endmodule

// File: tb/simd_pe_row_tb.sv
module simd_pe_row_tb_top;
  import pe_row_pkg::*;

  localparam int NPE = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [3:0]     op_i = '0, src_i = '0;
  logic [5:0]     laddr_i = '0, waddr_i = '0;
  logic [2:0]     raddr_i = '0;
  logic           wdst_i = 1'b0;
  logic [1:0]     cfg_i = '0;
  logic [NPE-1:0] above_i = '0, below_i = '0;
  logic [NPE-1:0] d1_o, d2_o, carry_o;

  always #2 clk = ~clk;

  simd_pe_row #(.NPE(NPE)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_i(src_i), .laddr_i(laddr_i),
    .raddr_i(raddr_i), .wdst_i(wdst_i), .waddr_i(waddr_i), .cfg_i(cfg_i),
    .above_i(above_i), .below_i(below_i), .d1_o(d1_o), .d2_o(d2_o), .carry_o(carry_o)
  );

  typedef struct {
    int             sel;
    logic [NPE-1:0] exp;
    string          req;
  } item_t;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;

  task automatic issue(pe_op_e o, pe_src_e s, int la, int ra, bit wd, int wa,
                       logic [1:0] cf, logic [NPE-1:0] av, logic [NPE-1:0] bv);
    @(negedge clk);
    op_i = o; src_i = s; laddr_i = la[5:0]; raddr_i = ra[2:0];
    wdst_i = wd; waddr_i = wa[5:0]; cfg_i = cf; above_i = av; below_i = bv;
  endtask

  task automatic nop(int la, int ra);
    issue(OP_NOP, SRC_SELF, la, ra, 1'b0, 0, 2'b00, '0, '0);
  endtask

  task automatic push(int sel, logic [NPE-1:0] e, string req);
    item_t it;
    it.sel = sel; it.exp = e; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic chk_left(int la, logic [NPE-1:0] e, string req);
    nop(la, 0);
    push(0, e, req);
  endtask

  task automatic chk_right(int ra, logic [NPE-1:0] e, string req);
    nop(0, ra);
    push(1, e, req);
  endtask

  task automatic chk_carry(logic [NPE-1:0] e, string req);
    nop(0, 0);
    push(2, e, req);
  endtask

  task automatic load_left(int wa, logic [NPE-1:0] v);
    issue(OP_PASS, SRC_ABOVE, wa ^ 1, 0, 1'b0, wa, 2'b00, v, '0);
  endtask

  task automatic load_right(int wa, logic [NPE-1:0] v);
    issue(OP_PASS, SRC_ABOVE, 0, (wa & 7) ^ 1, 1'b1, wa, 2'b00, v, '0);
  endtask

  // Bit-serial add or subtract of per-group integers with units of k elements.
  task automatic run_arith(int k, bit sub, int cyc, int unsigned xs[8],
                           int unsigned ys[8], string req);
    int             w;
    longint         m, xx, yy, s, mp, cc;
    logic [NPE-1:0] lv, rv, ev, ec;
    w = cyc * k;
    m = (longint'(1) << w) - 1;
    issue(OP_CFGC, SRC_SELF, 0, 0, 1'b0, 0, (k == 1) ? 2'b00 : (k == 2) ? 2'b10 : 2'b11, '0, '0);
    for (int c = 0; c < cyc; c++) begin
      for (int e = 0; e < NPE; e++) begin
        lv[e] = xs[e / k][c * k + (e % k)];
        rv[e] = ys[e / k][c * k + (e % k)];
      end
      load_left(10 + c, lv);
      load_right(c, rv);
    end
    issue(sub ? OP_SETC : OP_CLRC, SRC_SELF, 0, 0, 1'b0, 0, 2'b00, '0, '0);
    for (int c = 0; c < cyc; c++)
      issue(sub ? OP_SUB : OP_ADD, SRC_SELF, 10 + c, c, 1'b0, 20 + c, 2'b00, '0, '0);
    for (int e = 0; e < NPE; e++) begin
      xx = longint'(xs[e / k]) & m;
      yy = sub ? (~longint'(ys[e / k])) & m : longint'(ys[e / k]) & m;
      mp = (longint'(1) << ((cyc - 1) * k + (e % k) + 1)) - 1;
      cc = ((xx & mp) + (yy & mp) + longint'(sub)) >> ((cyc - 1) * k + (e % k) + 1);
      ec[e] = cc[0];
    end
    chk_carry(ec, req);
    for (int c = 0; c < cyc; c++) begin
      for (int e = 0; e < NPE; e++) begin
        xx = longint'(xs[e / k]) & m;
        yy = sub ? (~longint'(ys[e / k])) & m : longint'(ys[e / k]) & m;
        s  = xx + yy + longint'(sub);
        ev[e] = s[c * k + (e % k)];
      end
      chk_left(20 + c, ev, req);
    end
  endtask

  // Monitor: compares queued expectations 1 ns after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [NPE-1:0] act;
        it = sb_q.pop_front();
        act = (it.sel == 0) ? d1_o : (it.sel == 1) ? d2_o : carry_o;
        n_checks++;
        if (act !== it.exp) begin
          n_errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    chk_left(0, '0, "R1");
    chk_left(63, '0, "R1");
    chk_right(7, '0, "R1");
    chk_carry('0, "R1");

    // R2: logic opcodes and write destination
    load_left(0, 8'hC5);
    load_right(0, 8'h6C);
    issue(OP_AND,  SRC_SELF, 0, 0, 1'b0, 1, 2'b00, '0, '0);
    issue(OP_OR,   SRC_SELF, 0, 0, 1'b0, 2, 2'b00, '0, '0);
    issue(OP_XOR,  SRC_SELF, 0, 0, 1'b1, 1, 2'b00, '0, '0);
    issue(OP_PASS, SRC_SELF, 0, 0, 1'b0, 3, 2'b00, '0, '0);
    chk_left(1, 8'h44, "R2");
    chk_left(2, 8'hED, "R2");
    chk_right(1, 8'hA9, "R2");
    chk_left(3, 8'hC5, "R2");

    // R3: neighbour taps, left d = element i+d
    load_left(5, 8'hB2);
    issue(OP_PASS, SRC_LEFT1, 5, 0, 1'b0, 6, 2'b00, '0, '0);  chk_left(6, 8'h59, "R3");
    issue(OP_PASS, SRC_LEFT2, 5, 0, 1'b0, 6, 2'b00, '0, '0);  chk_left(6, 8'h2C, "R3");
    issue(OP_PASS, SRC_RIGHT1, 5, 0, 1'b0, 6, 2'b00, '0, '0); chk_left(6, 8'h64, "R3");
    issue(OP_PASS, SRC_RIGHT2, 5, 0, 1'b0, 6, 2'b00, '0, '0); chk_left(6, 8'hC8, "R3");
    issue(OP_PASS, SRC_BELOW, 5, 0, 1'b0, 6, 2'b00, 8'h5A, 8'hA5); chk_left(6, 8'hA5, "R3");
    issue(OP_PASS, SRC_ABOVE, 5, 0, 1'b0, 6, 2'b00, 8'h5A, 8'hA5); chk_left(6, 8'h5A, "R3");

    // R4: taps past the row ends read 0
    load_left(5, 8'hFF);
    issue(OP_PASS, SRC_LEFT4, 5, 0, 1'b0, 6, 2'b00, '0, '0);  chk_left(6, 8'h0F, "R4");
    issue(OP_PASS, SRC_RIGHT4, 5, 0, 1'b0, 6, 2'b00, '0, '0); chk_left(6, 8'hF0, "R4");
    issue(OP_PASS, SRC_LEFT1, 5, 0, 1'b0, 6, 2'b00, '0, '0);  chk_left(6, 8'h7F, "R4");

    // R5 / R6: independent elements, 4-bit add and subtract
    run_arith(1, 1'b0, 4, '{3, 5, 9, 15, 0, 7, 12, 10}, '{6, 11, 7, 1, 0, 9, 4, 15}, "R5");
    run_arith(1, 1'b1, 4, '{3, 5, 9, 15, 0, 7, 12, 10}, '{6, 11, 7, 1, 0, 9, 4, 15}, "R6");

    // R7: paired units, 4-bit values in two cycles
    run_arith(2, 1'b0, 2, '{9, 6, 15, 3, 0, 0, 0, 0}, '{8, 7, 1, 12, 0, 0, 0, 0}, "R7");
    run_arith(2, 1'b1, 2, '{9, 6, 15, 3, 0, 0, 0, 0}, '{8, 7, 1, 12, 0, 0, 0, 0}, "R7");

    // R8: quad units, 8-bit values in two cycles
    run_arith(4, 1'b0, 2, '{200, 77, 0, 0, 0, 0, 0, 0}, '{99, 180, 0, 0, 0, 0, 0, 0}, "R8");
    run_arith(4, 1'b1, 2, '{50, 10, 0, 0, 0, 0, 0, 0}, '{20, 30, 0, 0, 0, 0, 0, 0}, "R8");

    // R10: right write uses low address bits, left untouched
    load_right(50, 8'h96);
    chk_right(2, 8'h96, "R10");
    chk_left(50, 8'h00, "R10");

    // R9: conditional write-back
    issue(OP_LDV, SRC_ABOVE, 0, 0, 1'b0, 0, 2'b00, 8'h0F, '0);
    load_left(40, 8'hFF);
    chk_left(40, 8'h0F, "R9");
    issue(OP_LDV, SRC_ABOVE, 0, 0, 1'b0, 0, 2'b00, 8'hFF, '0);
    load_left(41, 8'hF0);
    chk_left(41, 8'hF0, "R9");

    // R11: NOP with busy fields changes nothing
    issue(OP_CLRC, SRC_SELF, 0, 0, 1'b0, 0, 2'b00, '0, '0);
    issue(OP_NOP, SRC_ABOVE, 1, 1, 1'b0, 40, 2'b11, 8'hFF, 8'hFF);
    chk_left(40, 8'h0F, "R11");
    chk_carry('0, "R11");

    nop(0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule